// File: doc/BRIEF.md
# Address-Masked APB GPIO Port

This block is an eight-pin general-purpose I/O peripheral that sits on an APB slave bus. Every pin has its own direction bit, interrupt enable bit and mode bit. The mode bit decides whether software registers drive the pin or a hardware alternate function does. The pad side is modelled as three plain vectors: sampled input levels, output values and output enables. A pad wrapper outside this block turns those vectors into real I/O cells.

The data register is not a single word. It spans a 1 KiB window, and address bits [9:2] of each access form a per-pin mask. A read returns only the pins whose mask bit is set, and every other pin reads as 0. A write changes only the masked pins. Because of this, driver code can set, clear or test one pin through that pin's own address alias, with no read-modify-write sequence and no lock.

Each pin can also raise an interrupt. The pin can be edge-detected, on a rising edge, a falling edge or both edges, or it can be level-detected with high or low as the active level. Software sees a raw status and a status filtered by the enables, and it can acknowledge latched edges through a write-one-to-clear register. One combined interrupt line is the OR of all enabled, pending pins.

Top module: `gpio_apb_port`

## Requirements
- R1: After reset, direction, interrupt configuration, enable, mode and output data are all 0. So pin_oe, pin_out and irq are 0, and every control register reads 0.
- R2: A read at an offset below 0x400 returns, for each pin i with paddr[2+i]=1, the output data bit if the pin is an output, or pin_in[i] if it is an input. Pins whose mask bit is 0 read as 0.
- R3: A write at an offset below 0x400 updates output data bit i only where paddr[2+i]=1. All other bits keep their value, and a write with mask 0 changes nothing.
- R4: Direction register, offset 0x400. Bit value 1 = output, 0 = input. In software mode, pin_oe[i] equals the direction bit and pin_out[i] equals the output data bit.
- R5: Mode register, offset 0x420. When bit i is 1, pin_out[i] and pin_oe[i] follow alt_out[i] and alt_oe[i].
- R6: Edge detection applies when the sense bit (offset 0x404) is 0 and the both-edges bit (0x408) is 0. Polarity bit (0x40C) = 1 selects a rising edge of pin_in and 0 a falling edge. The detected edge sets a sticky raw status bit (offset 0x414) at the first clock edge after pin_in changes.
- R7: When the sense bit is 0 and the both-edges bit is 1, either edge of the pin sets its raw status bit.
- R8: When the sense bit is 1, the raw status bit is live. It is 1 while pin_in[i] equals the polarity bit, and a clear write has no effect on it.
- R9: Masked status (offset 0x418) equals raw status AND the enable register (offset 0x410, 1 = enabled). irq is 1 exactly when some masked status bit is 1.
- R10: Writing 1 to bit i of the clear register (offset 0x41C) clears that pin's latched edge status, and writing 0 leaves it. A new edge in the same cycle wins over the clear.
- R11: The sense, both-edges, polarity, enable, direction and mode registers read back what was written. The clear register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 32 | Write data (low 8 bits used) |
| prdata | output | 32 | Read data, valid during a read access |
| pin_in | input | 8 | Sampled pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, a 12-bit address and a 32-bit data bus. At this size the full mask window 0x000–0x3FC and every control offset up to 0x420 can be reached. A handful of mask aliases is enough to cover each kind of case: an empty mask, a single pin, a subset and all pins, with inputs and outputs mixed in the same read. The eight-bit width also lets single pins exercise every interrupt mode side by side, including live level status that survives a clear write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // word offsets (byte offset >> 2) of the control registers
  localparam logic [9:0] WOFF_DIR   = 10'h100;
  localparam logic [9:0] WOFF_SENSE = 10'h101;
  localparam logic [9:0] WOFF_BOTH  = 10'h102;
  localparam logic [9:0] WOFF_POL   = 10'h103;
  localparam logic [9:0] WOFF_IEN   = 10'h104;
  localparam logic [9:0] WOFF_RAW   = 10'h105;
  localparam logic [9:0] WOFF_MSK   = 10'h106;
  localparam logic [9:0] WOFF_CLR   = 10'h107;
  localparam logic [9:0] WOFF_MODE  = 10'h108;

  // merge new bits into old where mask is set
  function automatic logic [7:0] mask_merge(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  // readback of the data window: outputs show the driven value, inputs the pad
  function automatic logic [7:0] data_view(input logic [7:0] dir,
                                           input logic [7:0] dout,
                                           input logic [7:0] pins,
                                           input logic [7:0] m);
    return ((dir & dout) | (~dir & pins)) & m;
  endfunction

  // edge hit per pin: both-edge, or polarity-selected single edge
  function automatic logic [7:0] edge_hit(input logic [7:0] cur,
                                          input logic [7:0] prev,
                                          input logic [7:0] both,
                                          input logic [7:0] pol);
    logic [7:0] rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
  endfunction

  // level match per pin: active when pin equals polarity
  function automatic logic [7:0] level_hit(input logic [7:0] cur,
                                           input logic [7:0] pol);
    return ~(cur ^ pol);
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  data_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  ien_q,
  output logic [NPINS-1:0]  mode_q,
  output logic              wr_data_evt,
  output logic [NPINS-1:0]  data_mask,
  output logic              clr_evt,
  output logic [NPINS-1:0]  clr_mask
);

  localparam int MSB_LO = NPINS + 2;

  logic              in_window;
  logic [ADDR_W-3:0] woff;
  logic [NPINS-1:0]  wbits;

  assign in_window   = (addr[ADDR_W-1:MSB_LO] == '0);
  assign woff        = addr[ADDR_W-1:2];
  assign data_mask   = addr[MSB_LO-1:2];
  assign wbits       = wdata[NPINS-1:0];
  assign wr_data_evt = wr_en && in_window;
  assign clr_evt     = wr_en && (woff == ADDR_W'(WOFF_CLR) >> 0);
  assign clr_mask    = wbits;

  function automatic logic hit(input logic [ADDR_W-3:0] w, input logic [9:0] o);
    return w == (ADDR_W-2)'(o);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      mode_q  <= '0;
    end else if (wr_en) begin
      if (in_window)              data_q  <= mask_merge(data_q, wbits, data_mask);
      if (hit(woff, WOFF_DIR))    dir_q   <= wbits;
      if (hit(woff, WOFF_SENSE))  sense_q <= wbits;
      if (hit(woff, WOFF_BOTH))   both_q  <= wbits;
      if (hit(woff, WOFF_POL))    pol_q   <= wbits;
      if (hit(woff, WOFF_IEN))    ien_q   <= wbits;
      if (hit(woff, WOFF_MODE))   mode_q  <= wbits;
    end
  end

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] ien,
  input  logic             clr_evt,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] prev_q,
  output logic [NPINS-1:0] edge_q,
  output logic [NPINS-1:0] edge_evt,
  output logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] msk,
  output logic             irq
);

  logic [NPINS-1:0] clr_bits;
  logic [NPINS-1:0] lvl;

  assign edge_evt = edge_hit(pin_in, prev_q, both, pol) & ~sense;
  assign lvl      = level_hit(pin_in, pol);
  assign clr_bits = clr_evt ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= pin_in;
      edge_q <= ((edge_q & ~clr_bits) | edge_evt) & ~sense;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_raw
    assign raw[i] = sense[i] ? lvl[i] : edge_q[i];
  end

  assign msk = raw & ien;
  assign irq = |msk;

endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] mode,
  input  logic [NPINS-1:0] sw_out,
  input  logic [NPINS-1:0] sw_oe,
  input  logic [NPINS-1:0] hw_out,
  input  logic [NPINS-1:0] hw_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_out[i] = mode[i] ? hw_out[i] : sw_out[i];
    assign pad_oe[i]  = mode[i] ? hw_oe[i]  : sw_oe[i];
  end

endmodule

// File: rtl/gpio_apb_port.sv
module gpio_apb_port
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic              irq
);

  localparam int MSB_LO = NPINS + 2;

  logic             wr_en, rd_en;
  logic [NPINS-1:0] data_q, dir_q, sense_q, both_q, pol_q, ien_q, mode_q;
  logic             wr_data_evt, clr_evt;
  logic [NPINS-1:0] data_mask, clr_mask;
  logic [NPINS-1:0] prev_q, edge_q, edge_evt, raw, msk;
  logic [NPINS-1:0] rd_bits;

  assign wr_en = psel && penable && pwrite;
  assign rd_en = psel && !pwrite;

  gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
    .data_q(data_q), .dir_q(dir_q), .sense_q(sense_q), .both_q(both_q),
    .pol_q(pol_q), .ien_q(ien_q), .mode_q(mode_q),
    .wr_data_evt(wr_data_evt), .data_mask(data_mask),
    .clr_evt(clr_evt), .clr_mask(clr_mask)
  );

  gpio_irq #(.NPINS(NPINS)) u_irq (
    .clk(pclk), .rst_n(presetn), .pin_in(pin_in),
    .sense(sense_q), .both(both_q), .pol(pol_q), .ien(ien_q),
    .clr_evt(clr_evt), .clr_mask(clr_mask),
    .prev_q(prev_q), .edge_q(edge_q), .edge_evt(edge_evt),
    .raw(raw), .msk(msk), .irq(irq)
  );

  gpio_padmux #(.NPINS(NPINS)) u_mux (
    .mode(mode_q), .sw_out(data_q), .sw_oe(dir_q),
    .hw_out(alt_out), .hw_oe(alt_oe),
    .pad_out(pin_out), .pad_oe(pin_oe)
  );

  always_comb begin
    rd_bits = '0;
    if (paddr[ADDR_W-1:MSB_LO] == '0) begin
      rd_bits = data_view(dir_q, data_q, pin_in, paddr[MSB_LO-1:2]);
    end else begin
      case (paddr[ADDR_W-1:2])
        (ADDR_W-2)'(WOFF_DIR):   rd_bits = dir_q;
        (ADDR_W-2)'(WOFF_SENSE): rd_bits = sense_q;
        (ADDR_W-2)'(WOFF_BOTH):  rd_bits = both_q;
        (ADDR_W-2)'(WOFF_POL):   rd_bits = pol_q;
        (ADDR_W-2)'(WOFF_IEN):   rd_bits = ien_q;
        (ADDR_W-2)'(WOFF_RAW):   rd_bits = raw;
        (ADDR_W-2)'(WOFF_MSK):   rd_bits = msk;
        (ADDR_W-2)'(WOFF_MODE):  rd_bits = mode_q;
        default:                 rd_bits = '0;
      endcase
    end
  end

  assign prdata = rd_en ? DATA_W'(rd_bits) : '0;

endmodule

// File: rtl/gpio_apb_port_chk.sv
module gpio_apb_port_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_data_evt,
  input logic [NPINS-1:0] data_mask,
  input logic [NPINS-1:0] data_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] mode_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] sense_q,
  input logic [NPINS-1:0] edge_q,
  input logic [NPINS-1:0] edge_evt,
  input logic             clr_evt,
  input logic [NPINS-1:0] clr_mask,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && !irq));

  // R3
  empty_mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_evt && data_mask == '0) |=> $stable(data_q));

  // R3
  unmasked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_evt |=> ((data_q ^ $past(data_q)) & ~$past(data_mask)) == '0);

  // R4
  sw_oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe ^ dir_q) & ~mode_q) == '0);

  // R6
  edge_set_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(edge_evt)) == '0));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R10
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && edge_evt == '0) |=> ((edge_q & $past(clr_mask)) == '0));

  // R8
  level_pins_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q & sense_q & $past(sense_q)) == '0);

endmodule

bind gpio_apb_port gpio_apb_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(pclk), .rst_n(presetn), .wr_data_evt(wr_data_evt), .data_mask(data_mask),
  .data_q(data_q), .dir_q(dir_q), .mode_q(mode_q), .ien_q(ien_q),
  .sense_q(sense_q), .edge_q(edge_q), .edge_evt(edge_evt),
  .clr_evt(clr_evt), .clr_mask(clr_mask), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/test_gpio_apb_port.sv
module test_gpio_apb_port;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  // vector: {is_write, addr[11:0], wdata[7:0], pins[7:0], expected[7:0]}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 12'h400, 8'h0F, 8'h00, 8'h00},  // R4 lower nibble outputs
    {1'b1, 12'h3FC, 8'hA5, 8'h00, 8'h00},  // R3 full-mask write
    {1'b0, 12'h3FC, 8'h00, 8'h30, 8'h35},  // R2 mixed in/out read
    {1'b1, 12'h004, 8'h00, 8'h30, 8'h00},  // R3 single-pin clear of bit0
    {1'b0, 12'h3FC, 8'h00, 8'h00, 8'h04},  // R3 only bit0 changed
    {1'b0, 12'h030, 8'h00, 8'hF0, 8'h04},  // R2 subset mask hides inputs
    {1'b1, 12'h3C0, 8'hFF, 8'hF0, 8'h00},  // R3 upper-nibble write
    {1'b0, 12'h3FC, 8'h00, 8'h00, 8'h04},  // R2 inputs show pads, not data
    {1'b1, 12'h000, 8'hFF, 8'h00, 8'h00},  // R3 empty mask write
    {1'b0, 12'h3FC, 8'h00, 8'h00, 8'h04},  // R3 nothing changed
    {1'b1, 12'h400, 8'hFF, 8'h00, 8'h00},  // R4 all outputs
    {1'b0, 12'h3FC, 8'h00, 8'h5A, 8'hF4},  // R2 outputs show data
    {1'b0, 12'h400, 8'h00, 8'h00, 8'hFF},  // R11 dir readback
    {1'b1, 12'h420, 8'h81, 8'h00, 8'h00},  // R5 mode write
    {1'b0, 12'h420, 8'h00, 8'h00, 8'h81},  // R11 mode readback
    {1'b0, 12'h500, 8'h00, 8'h00, 8'h00}   // R11 unmapped reads 0
  };

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  gpio_apb_port i_gpio_apb_port (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = {24'h0, d}; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 v = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge pclk);
    pin_in = v;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] e);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, {24'h0, e});
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    // R1 reset state
    check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {24'h0, pin_out}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd_chk("R1 dir", 12'h400, 8'h00);
    rd_chk("R1 ien", 12'h410, 8'h00);
    rd_chk("R1 mode", 12'h420, 8'h00);

    // table walk
    for (int k = 0; k < NV; k++) begin
      pins(VEC[k][15:8]);
      if (VEC[k][36]) wr(VEC[k][35:24], VEC[k][23:16]);
      else begin
        rd(VEC[k][35:24], v);
        check($sformatf("vector %0d", k), v, {24'h0, VEC[k][7:0]});
      end
    end

    // R5 alternate function takes pins 0 and 7
    wr(12'h400, 8'h02);
    wr(12'h3FC, 8'h02);
    @(negedge pclk);
    alt_out = 8'h01; alt_oe = 8'h81;
    #1;
    check("R5 pin_out", {24'h0, pin_out}, 32'h03);
    check("R5 pin_oe", {24'h0, pin_oe}, 32'h83);
    check("R4 sw pins", {24'h0, pin_oe & 8'h7E}, 32'h02);
    wr(12'h420, 8'h00);
    wr(12'h400, 8'h00);

    // interrupt setup: rising edge on pin0
    pins(8'h00);
    wr(12'h40C, 8'h01);
    wr(12'h410, 8'h01);
    wr(12'h41C, 8'hFF);
    rd_chk("R11 pol readback", 12'h40C, 8'h01);
    pins(8'h01);
    rd_chk("R6 rise latched", 12'h414, 8'h01);
    rd_chk("R9 masked", 12'h418, 8'h01);
    check("R9 irq high", {31'h0, irq}, 32'h1);
    wr(12'h41C, 8'h01);
    rd_chk("R10 cleared", 12'h414, 8'h00);
    check("R9 irq low", {31'h0, irq}, 32'h0);
    pins(8'h00);
    rd_chk("R6 fall ignored", 12'h414, 8'h00);

    // R7 both edges on pin1
    wr(12'h408, 8'h02);
    rd_chk("R11 both readback", 12'h408, 8'h02);
    pins(8'h02);
    rd_chk("R7 rise", 12'h414, 8'h02);
    wr(12'h41C, 8'h02);
    pins(8'h00);
    rd_chk("R7 fall", 12'h414, 8'h02);
    wr(12'h41C, 8'h00);
    rd_chk("R10 zero write no effect", 12'h414, 8'h02);
    rd_chk("R10 clear reads 0", 12'h41C, 8'h00);
    wr(12'h41C, 8'hFF);

    // R8 level-high on pin2
    wr(12'h404, 8'h04);
    wr(12'h40C, 8'h05);
    rd_chk("R11 sense readback", 12'h404, 8'h04);
    rd_chk("R8 inactive level", 12'h414, 8'h00);
    pins(8'h04);
    rd_chk("R8 active level", 12'h414, 8'h04);
    wr(12'h41C, 8'h04);
    rd_chk("R8 clear no effect", 12'h414, 8'h04);
    wr(12'h410, 8'h04);
    rd_chk("R9 level masked", 12'h418, 8'h04);
    check("R9 irq level", {31'h0, irq}, 32'h1);
    wr(12'h410, 8'h00);
    rd_chk("R9 disabled masked", 12'h418, 8'h00);
    check("R9 irq disabled", {31'h0, irq}, 32'h0);
    rd_chk("R9 raw still set", 12'h414, 8'h04);
    pins(8'h00);
    rd_chk("R8 level released", 12'h414, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule